// File: doc/BRIEF.md
# Multi-Channel PWM Timer with Buffered Compare Values

This block is a PWM timer for a peripheral subsystem. One free-running counter, slowed by a programmable clock divider, is shared by six output channels. A period compare value sets where the counter wraps, so every channel runs at the same period. Each channel has its own compare value. That value sets how many counter ticks the channel stays high at the start of each period.

Software writes compare values into staging copies over a small synchronous register bus. A staged value does not change the running waveform on its own. It is copied into the live compare register only at a period boundary, and only if its bit in the commit-mask register is set. Once the copy is made, that bit clears. Because of this, several channels and the period can be retuned together without producing a malformed cycle.

Top module: `pwm_timer`

Register addresses:

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Divider value |
| 2 | Commit mask |
| 3 + k | Compare k (k = 0 for the period, 1..6 for the channels) |

Control bits:

| Bit | Meaning |
|---|---|
| 0 | Count enable |
| 1 | Counter reset |
| 3 | Output enable |

Bit k of the commit mask belongs to compare k.

## Requirements
- R1: After `rst_n` is released, every output is low and every register reads 0.
- R2: With the divider at 0, the counter counts 0 up to the live period compare P and then returns to 0, so one period lasts P+1 ticks.
- R3: Channel n is high from the start of each period while the counter is below its live compare Mn, and low from the count Mn to the end of the period. It is therefore high for Mn ticks of every period.
- R4: A channel whose live compare is 0 stays low for the whole period. A channel whose live compare is greater than P stays high for the whole period.
- R5: A compare write only updates the staging copy. The staged value becomes live at a period boundary only when its commit-mask bit is set. Mask bits are set by writing ones to address 2 and clear when the commit happens. A staged value whose mask bit is not set leaves the output unchanged.
- R6: With divider value D, the counter advances once every D+1 clocks. This makes the period (P+1)*(D+1) clocks and the high time Mn*(D+1) clocks.
- R7: While control bit 1 is set, the counter and the divider are held at 0 and all outputs are low.
- R8: While control bit 3 is clear, all outputs are low.
- R9: While control bit 0 is clear, the counter does not advance, so the outputs keep their levels.
- R10: A read returns the register at the address present at the previous clock edge, one cycle later. Compare addresses return the staging copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| pwmOut | output | 6 | Channel outputs, bit n-1 is channel n |

## Verification
The bench targets the compare extremes: a compare of 0 must give a flat low output, and a compare above the period must give a flat high output. A design that compared with the wrong inequality would leak a one-tick glitch in either case.

It writes a staged value without setting its mask bit and checks that the waveform keeps its old duty. A design that let staged values through directly would show the new duty at once. It also confirms that mask bits read back as clear after a commit; a design that never cleared them would re-commit stale values.

Divider and wrap timing are measured edge to edge, which exposes off-by-one errors in either counter. Random register traffic then covers divider changes in the middle of a count and writes that land on a boundary cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_DIV     = 1;
  localparam int ADDR_MASK    = 2;
  localparam int ADDR_MR_BASE = 3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_RST_BIT = 1;
  localparam int CTRL_OUT_BIT = 3;

  typedef struct packed {
    logic cntEn;
    logic cntRst;
    logic outEn;
  } ctrl_strobe_t;

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int NUM_MR = 7,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic                              busWrEn,
  input  logic [DATA_W-1:0]                 busWrData,
  input  logic                              periodEnd,
  output logic [DATA_W-1:0]                 busRdData,
  output ctrl_strobe_t                      ctrlStb,
  output logic [CNT_W-1:0]                  divValue,
  output logic [NUM_MR-1:0][CNT_W-1:0]      stageVal,
  output logic [NUM_MR-1:0]                 commitMask
);

  logic cntEnQ, cntRstQ, outEnQ;
  logic [CNT_W-1:0] divQ;
  logic [NUM_MR-1:0] maskQ, maskD;
  logic [DATA_W-1:0] rdNext;

  logic wrCtrl, wrDiv, wrMask;
  assign wrCtrl = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL));
  assign wrDiv  = busWrEn && (busAddr == ADDR_W'(ADDR_DIV));
  assign wrMask = busWrEn && (busAddr == ADDR_W'(ADDR_MASK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntEnQ  <= 1'b0;
      cntRstQ <= 1'b0;
      outEnQ  <= 1'b0;
      divQ    <= '0;
    end else begin
      if (wrCtrl) begin
        cntEnQ  <= busWrData[CTRL_EN_BIT];
        cntRstQ <= busWrData[CTRL_RST_BIT];
        outEnQ  <= busWrData[CTRL_OUT_BIT];
      end
      if (wrDiv) divQ <= busWrData[CNT_W-1:0];
    end
  end

  // committed bits drop at the boundary; bits written this cycle survive
  always_comb begin
    maskD = periodEnd ? '0 : maskQ;
    if (wrMask) maskD = maskD | busWrData[NUM_MR-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) maskQ <= '0;
    else        maskQ <= maskD;
  end

  for (genvar i = 0; i < NUM_MR; i++) begin : g_stage
    logic hit;
    assign hit = busWrEn && (busAddr == ADDR_W'(ADDR_MR_BASE + i));
    always_ff @(posedge clk) begin
      if (!rst_n)   stageVal[i] <= '0;
      else if (hit) stageVal[i] <= busWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    rdNext = '0;
    if (busAddr == ADDR_W'(ADDR_CTRL)) begin
      rdNext[CTRL_EN_BIT]  = cntEnQ;
      rdNext[CTRL_RST_BIT] = cntRstQ;
      rdNext[CTRL_OUT_BIT] = outEnQ;
    end else if (busAddr == ADDR_W'(ADDR_DIV)) begin
      rdNext = DATA_W'(divQ);
    end else if (busAddr == ADDR_W'(ADDR_MASK)) begin
      rdNext = DATA_W'(maskQ);
    end else begin
      for (int i = 0; i < NUM_MR; i++) begin
        if (busAddr == ADDR_W'(ADDR_MR_BASE + i)) rdNext = DATA_W'(stageVal[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busRdData <= '0;
    else        busRdData <= rdNext;
  end

  assign ctrlStb.cntEn  = cntEnQ;
  assign ctrlStb.cntRst = cntRstQ;
  assign ctrlStb.outEn  = outEnQ;
  assign divValue   = divQ;
  assign commitMask = maskQ;

endmodule

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  localparam int NUM_MR = NUM_CH + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctrl_strobe_t                  ctrlStb,
  input  logic [CNT_W-1:0]              divValue,
  input  logic [NUM_MR-1:0][CNT_W-1:0]  stageVal,
  input  logic [NUM_MR-1:0]             commitMask,
  output logic                          periodEnd,
  output logic [NUM_CH-1:0]             pwmOut
);

  logic [CNT_W-1:0] divQ;
  logic [CNT_W-1:0] cntQ;
  logic [NUM_MR-1:0][CNT_W-1:0] activeQ;
  logic tick, running;

  assign running   = ctrlStb.cntEn && !ctrlStb.cntRst;
  // >= keeps the divider from stalling when its limit is lowered mid-count
  assign tick      = running && (divQ >= divValue);
  assign periodEnd = tick && (cntQ >= activeQ[0]);

  always_ff @(posedge clk) begin
    if (!rst_n || ctrlStb.cntRst) begin
      divQ <= '0;
      cntQ <= '0;
    end else if (ctrlStb.cntEn) begin
      divQ <= tick ? '0 : divQ + 1'b1;
      if (tick) cntQ <= periodEnd ? '0 : cntQ + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_MR; i++) begin : g_active
    always_ff @(posedge clk) begin
      if (!rst_n)                            activeQ[i] <= '0;
      else if (periodEnd && commitMask[i])   activeQ[i] <= stageVal[i];
    end
  end

  for (genvar n = 1; n <= NUM_CH; n++) begin : g_out
    assign pwmOut[n-1] = ctrlStb.outEn && !ctrlStb.cntRst && (cntQ < activeQ[n]);
  end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);

  localparam int NUM_MR = NUM_CH + 1;

  ctrl_strobe_t                 ctrlStb;
  logic [CNT_W-1:0]             divValue;
  logic [NUM_MR-1:0][CNT_W-1:0] stageVal;
  logic [NUM_MR-1:0]            commitMask;
  logic                         periodEnd;

  pwm_timer_regs #(
    .NUM_MR(NUM_MR), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .periodEnd(periodEnd), .busRdData(busRdData),
    .ctrlStb(ctrlStb), .divValue(divValue), .stageVal(stageVal),
    .commitMask(commitMask)
  );

  pwm_timer_dp #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrlStb(ctrlStb), .divValue(divValue),
    .stageVal(stageVal), .commitMask(commitMask), .periodEnd(periodEnd),
    .pwmOut(pwmOut)
  );

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  localparam int NUM_MR = NUM_CH + 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cntEn,
  input logic                          cntRst,
  input logic                          outEn,
  input logic                          periodEnd,
  input logic                          maskWr,
  input logic [NUM_MR-1:0]             maskQ,
  input logic [CNT_W-1:0]              cnt,
  input logic [NUM_MR-1:0][CNT_W-1:0]  active,
  input logic [NUM_CH-1:0]             pwmOut
);

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= active[0]);

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd |=> cnt == '0);

  p_rst_holds_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cntRst |=> cnt == '0);

  p_rst_outputs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cntRst |-> pwmOut == '0);

  p_out_disabled_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !outEn |-> pwmOut == '0);

  p_stopped_cnt_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntEn && !cntRst) |=> $stable(cnt));

  p_mask_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (periodEnd && !maskWr) |=> maskQ == '0);

  p_live_only_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !periodEnd |=> $stable(active));

endmodule

bind pwm_timer pwm_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cntEn(ctrlStb.cntEn), .cntRst(ctrlStb.cntRst), .outEn(ctrlStb.outEn),
  .periodEnd(periodEnd),
  .maskWr(busWrEn && (busAddr == ADDR_W'(2))),
  .maskQ(commitMask),
  .cnt(u_dp.cntQ), .active(u_dp.activeQ),
  .pwmOut(pwmOut)
);

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int NMR = NCH + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NCH-1:0] pwmOut;

  int checks = 0;
  int errors = 0;

  pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model built from the requirements ----------
  logic        mEn, mRst, mOut;
  logic [31:0] mDiv, mDivCnt, mCnt, mRd;
  logic [NMR-1:0] mMask;
  logic [31:0] mStage [NMR];
  logic [31:0] mLive  [NMR];

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 4'd0) begin v[0] = mEn; v[1] = mRst; v[3] = mOut; end
    else if (a == 4'd1) v = mDiv;
    else if (a == 4'd2) v = 32'(mMask);
    else if (a >= 4'd3 && a <= 4'd9) v = mStage[a-3];
    return v;
  endfunction

  function automatic logic [NCH-1:0] modelOut();
    logic [NCH-1:0] o;
    for (int n = 1; n <= NCH; n++)
      o[n-1] = mOut && !mRst && (mCnt < mLive[n]);
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mEn = 0; mRst = 0; mOut = 0; mDiv = 0; mDivCnt = 0; mCnt = 0;
      mRd = 0; mMask = 0;
      for (int i = 0; i < NMR; i++) begin mStage[i] = 0; mLive[i] = 0; end
    end else begin
      logic adv, boundary;
      mRd = modelRead(busAddr);
      adv = mEn && !mRst && (mDivCnt >= mDiv);
      boundary = adv && (mCnt >= mLive[0]);
      if (boundary)
        for (int i = 0; i < NMR; i++) if (mMask[i]) mLive[i] = mStage[i];
      if (boundary) mMask = '0;
      if (mRst) begin mDivCnt = 0; mCnt = 0; end
      else if (mEn) begin
        mDivCnt = adv ? 0 : mDivCnt + 1;
        if (adv) mCnt = boundary ? 0 : mCnt + 1;
      end
      if (busWrEn) begin
        case (busAddr)
          4'd0: begin mEn = busWrData[0]; mRst = busWrData[1]; mOut = busWrData[3]; end
          4'd1: mDiv = busWrData;
          4'd2: mMask = mMask | busWrData[NMR-1:0];
          default: if (busAddr >= 4'd3 && busAddr <= 4'd9) mStage[busAddr-3] = busWrData;
        endcase
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: inputs held, sample at the following falling edge
  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      logic [NCH-1:0] eo;
      eo = modelOut();
      check(pwmOut == eo, "R3", "outputs vs model", pwmOut, eo);
      check(busRdData == mRd, "R10", "read data vs model", busRdData, mRd);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    cyc();
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    cyc();
    d = busRdData;
  endtask

  task automatic highCount(input int ch, input int n, output int hc);
    hc = 0;
    for (int i = 0; i < n; i++) begin cyc(); if (pwmOut[ch]) hc++; end
  endtask

  task automatic riseToRise(input int ch, output int len);
    logic prev;
    int guard;
    len = 0; guard = 0;
    prev = pwmOut[ch];
    while (!(prev == 1'b0 && pwmOut[ch] == 1'b1) && guard < 1000) begin
      prev = pwmOut[ch]; cyc(); guard++;
    end
    prev = pwmOut[ch];
    guard = 0;
    do begin prev = pwmOut[ch]; cyc(); len++; guard++; end
    while (!(prev == 1'b0 && pwmOut[ch] == 1'b1) && guard < 1000);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int hc, len;
    logic [31:0] d;
    logic [NCH-1:0] frozen;
    bit same;
    void'($urandom(32'd20240611));

    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    check(pwmOut == '0, "R1", "outputs after reset", pwmOut, 0);
    rd(4'd0, d); check(d == 0, "R1", "control after reset", d, 0);
    rd(4'd9, d); check(d == 0, "R1", "compare 6 after reset", d, 0);

    // period 19, ch6 9, ch1 0, ch2 25, ch3 18
    wr(4'd3, 18); wr(4'd9, 9); wr(4'd4, 0); wr(4'd5, 25); wr(4'd6, 18);
    wr(4'd2, 32'h4F);
    wr(4'd0, 32'h9);
    idle(5);
    rd(4'd2, d); check(d == 0, "R5", "mask cleared after commit", d, 0);
    highCount(5, 19, hc); check(hc == 9, "R3", "ch6 high ticks", hc, 9);
    riseToRise(5, len);  check(len == 19, "R2", "period length", len, 19);
    highCount(0, 19, hc); check(hc == 0, "R4", "compare 0 stays low", hc, 0);
    highCount(1, 19, hc); check(hc == 19, "R4", "compare above period stays high", hc, 19);
    highCount(2, 19, hc); check(hc == 18, "R3", "compare equal to period", hc, 18);

    // staged only, no mask bit
    wr(4'd9, 3);
    idle(40);
    highCount(5, 19, hc); check(hc == 9, "R5", "unmasked stage ignored", hc, 9);
    rd(4'd9, d); check(d == 3, "R10", "compare reads staging copy", d, 3);
    wr(4'd2, 32'h40);
    idle(40);
    highCount(5, 19, hc); check(hc == 3, "R5", "masked stage committed", hc, 3);

    // divider
    wr(4'd1, 2); wr(4'd9, 9); wr(4'd2, 32'h40);
    idle(120);
    highCount(5, 57, hc); check(hc == 27, "R6", "high clocks with divider", hc, 27);
    riseToRise(5, len);  check(len == 57, "R6", "period clocks with divider", len, 57);

    // count disabled: outputs frozen
    wr(4'd0, 32'h8);
    frozen = pwmOut; same = 1;
    for (int i = 0; i < 30; i++) begin cyc(); if (pwmOut != frozen) same = 0; end
    check(same, "R9", "outputs frozen while stopped", pwmOut, frozen);

    // counter reset
    wr(4'd0, 32'hB);
    highCount(1, 20, hc); check(hc == 0, "R7", "outputs low under counter reset", hc, 0);
    // output disable with counting on
    wr(4'd0, 32'h1);
    highCount(1, 30, hc); check(hc == 0, "R8", "outputs low with output enable clear", hc, 0);
    wr(4'd0, 32'h9); wr(4'd1, 0);
    idle(60);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      busAddr = 4'($urandom_range(0, 10));
      if (r < 12) begin
        logic [31:0] v;
        case (busAddr)
          4'd0: v = ($urandom_range(0, 9) == 0) ? 32'hB : {28'd0, 1'b1, 1'b0, 1'b0, 1'($urandom_range(0, 5) != 0)};
          4'd1: v = $urandom_range(0, 3);
          4'd2: v = $urandom_range(0, 127);
          default: v = $urandom_range(0, 30);
        endcase
        wr(busAddr, v);
      end else cyc();
    end

    finishRun();
  end

endmodule